// File: doc/BRIEF.md
# Double-Precision Adder Front End

This block forms the part of a double-precision floating-point adder that comes before rounding. It takes two 64-bit IEEE 754 binary64 operands and a two-bit rounding mode. Each operand is classified, and the block settles every case that has a fixed answer: NaNs, infinities, zeros and exact cancellation. For those cases it delivers a finished 64-bit word together with an invalid-operation flag.

When both operands are finite and at least one of them is nonzero, the block does the arithmetic instead. It normalizes any subnormal input and aligns the two significands, with a sticky bit collecting what the alignment shifts out. It then adds or subtracts the significands according to the signs and renormalizes the result. The output is a sign, a signed 13-bit biased exponent that can fall below the normal range, and a 56-bit significand that carries guard, round and sticky bits. A downstream rounder consumes this output.

One set of operands is accepted per cycle when the input strobe is high. The result appears on the registered outputs one cycle later, and out_special tells the rounder whether the word is already final.

Top module: `dp_add_front`

## Requirements
- R1: While rst is high at a clock edge, every output register clears: out_vld, out_special, out_invalid and out_sign become 0, and out_value, out_exp and out_mant become all zeros.
- R2: A result appears on the edge that follows the edge on which in_vld was sampled high, and out_vld is high in exactly that cycle. When in_vld is low, out_vld goes low and every data output keeps its previous value.
- R3: A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 51 clear. When either operand is a signaling NaN, out_invalid is 1 and out_value is that operand with bit 51 set. Operand A wins when both operands are signaling NaNs.
- R4: A quiet NaN has an all-ones exponent and fraction bit 51 set. When neither operand is a signaling NaN, a quiet NaN in A is returned unchanged; failing that, a quiet NaN in B is returned unchanged. out_invalid is 0 in both cases.
- R5: Two infinities of equal sign return that infinity. Two infinities of opposite sign return 64'h7FF8000000000000 with out_invalid set.
- R6: An infinity paired with a zero or a finite operand returns the infinity operand unchanged.
- R7: Zero plus zero of equal sign returns operand A. Zeros of opposite sign return a zero whose sign bit is 1 only when rm is 2'b11 (round toward minus infinity). The other encodings are 2'b00 nearest, 2'b01 toward zero and 2'b10 toward plus infinity.
- R8: A zero paired with a nonzero finite operand returns the other operand unchanged.
- R9: A subnormal operand is treated as having biased exponent 1. Its significand is shifted left until the hidden bit is set, and its exponent is lowered by the shift count, so out_exp can be zero or negative (two's complement).
- R10: The significand layout is: out_mant[55] is the hidden bit, out_mant[54:3] is the fraction, and out_mant[2:0] are guard, round and sticky. The operand with the smaller exponent is shifted right by the exponent difference, every bit shifted out is ORed into bit 0, and the result takes the larger exponent.
- R11: With equal signs the significands are added. A carry out of bit 55 shifts the sum right by one with the lost bit ORed into bit 0, and the exponent increments.
- R12: With different signs the smaller aligned significand is subtracted from the larger, and the result takes the sign of the larger one. An exact zero difference is returned as a finished zero whose sign follows the rule in R7.
- R13: Every non-special result has out_mant[55] set. After a subtraction, the exponent is lowered once for each left shift needed to reach that state.
- R14: For a special result out_sign, out_exp and out_mant are zero. For a non-special result out_value and out_invalid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and rounding mode are valid this cycle |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| rm | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_vld | output | 1 | Result registers were loaded on the last edge |
| out_special | output | 1 | out_value holds a finished result that needs no rounding |
| out_value | output | 64 | Finished special result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_sign | output | 1 | Sign of the unrounded result |
| out_exp | output | 13 | Signed biased exponent of the unrounded result |
| out_mant | output | 56 | Normalized significand with guard, round and sticky |

## Verification
The carry-out right shift and the alignment sticky can act on the same result. One such case adds an all-ones significand to an operand 52 binades lower whose low fraction bit is set. The alignment leaves a sticky 1 in bit 0, and the sum carries out, so the renormalizing shift must keep that sticky rather than drop it. The bench checks the exact 56-bit significand and the incremented exponent. A second case combines cancellation with sticky: subtracting a far smaller operand makes a borrow run through the sticky position, and the one-place left normalization must carry the result with a zero in bit 0 and a decremented exponent.

// File: rtl/dpadd_pkg.sv
package dpadd_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int GRS_W  = 3;
    localparam int XM_W   = SIG_W + GRS_W;
    localparam int XE_W   = EXP_W + 2;
    localparam int LZ_W   = $clog2(XM_W + 1);

    localparam logic [1:0] RM_DOWN = 2'b11;

    localparam logic [EXP_W-1:0]  EXP_TOP      = '1;
    localparam logic [WORD_W-1:0] QNAN_DEFAULT = {1'b0, EXP_TOP, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_e;

    typedef struct packed {
        logic                    sign;
        logic signed [XE_W-1:0]  exp;
        logic [XM_W-1:0]         mant;
    } wide_num_t;

    typedef struct packed {
        logic              special;
        logic [WORD_W-1:0] value;
        logic              invalid;
    } spec_res_t;

    function automatic opclass_e classify(input logic [WORD_W-1:0] f);
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] m;
        e = f[WORD_W-2:FRAC_W];
        m = f[FRAC_W-1:0];
        if (e == EXP_TOP) begin
            if (m == '0)            return CL_INF;
            else if (m[FRAC_W-1])   return CL_QNAN;
            else                    return CL_SNAN;
        end
        if (e == '0) return (m == '0) ? CL_ZERO : CL_SUB;
        return CL_NORM;
    endfunction

    function automatic logic [WORD_W-1:0] quieten(input logic [WORD_W-1:0] f);
        return {f[WORD_W-1:FRAC_W], 1'b1, f[FRAC_W-2:0]};
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [XM_W-1:0] m);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = LZ_W'(XM_W);
        hit = 1'b0;
        for (int i = XM_W - 1; i >= 0; i--) begin
            if (!hit && m[i]) begin
                n   = LZ_W'(XM_W - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [XM_W-1:0] shr_sticky(input logic [XM_W-1:0] m,
                                                   input logic [XE_W-1:0] sh);
        logic [XM_W-1:0] kept;
        logic [XM_W-1:0] lost_mask;
        if (sh >= XE_W'(XM_W)) return {{(XM_W-1){1'b0}}, |m};
        kept      = m >> sh;
        lost_mask = ~({XM_W{1'b1}} << sh);
        return kept | {{(XM_W-1){1'b0}}, |(m & lost_mask)};
    endfunction

endpackage

// File: rtl/dpadd_unpack.sv
module dpadd_unpack
    import dpadd_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output opclass_e          cls,
    output wide_num_t         num
);

    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] frac;
    logic [XM_W-1:0]   raw;
    logic [LZ_W-1:0]   lz;

    always_comb begin
        efield   = op[WORD_W-2:FRAC_W];
        frac     = op[FRAC_W-1:0];
        cls      = classify(op);
        raw      = {1'b0, frac, {GRS_W{1'b0}}};
        lz       = lead_zeros(raw);
        num.sign = op[WORD_W-1];
        case (cls)
            CL_NORM: begin
                num.exp  = XE_W'(efield);
                num.mant = {1'b1, frac, {GRS_W{1'b0}}};
            end
            CL_SUB: begin
                num.exp  = XE_W'(1) - XE_W'(lz);
                num.mant = raw << lz;
            end
            default: begin
                num.exp  = '0;
                num.mant = '0;
            end
        endcase
    end

endmodule

// File: rtl/dpadd_special.sv
module dpadd_special
    import dpadd_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  opclass_e          cls_a,
    input  opclass_e          cls_b,
    input  logic [1:0]        rm,
    output spec_res_t         res
);

    logic sa;
    logic sb;

    always_comb begin
        sa  = a[WORD_W-1];
        sb  = b[WORD_W-1];
        res = '0;
        if (cls_a == CL_SNAN) begin
            res = '{special: 1'b1, value: quieten(a), invalid: 1'b1};
        end else if (cls_b == CL_SNAN) begin
            res = '{special: 1'b1, value: quieten(b), invalid: 1'b1};
        end else if (cls_a == CL_QNAN) begin
            res = '{special: 1'b1, value: a, invalid: 1'b0};
        end else if (cls_b == CL_QNAN) begin
            res = '{special: 1'b1, value: b, invalid: 1'b0};
        end else if (cls_a == CL_INF && cls_b == CL_INF) begin
            if (sa == sb) res = '{special: 1'b1, value: a, invalid: 1'b0};
            else          res = '{special: 1'b1, value: QNAN_DEFAULT, invalid: 1'b1};
        end else if (cls_a == CL_INF) begin
            res = '{special: 1'b1, value: a, invalid: 1'b0};
        end else if (cls_b == CL_INF) begin
            res = '{special: 1'b1, value: b, invalid: 1'b0};
        end else if (cls_a == CL_ZERO && cls_b == CL_ZERO) begin
            if (sa == sb) res = '{special: 1'b1, value: a, invalid: 1'b0};
            else          res = '{special: 1'b1,
                                  value: {rm == RM_DOWN, {(WORD_W-1){1'b0}}},
                                  invalid: 1'b0};
        end else if (cls_a == CL_ZERO) begin
            res = '{special: 1'b1, value: b, invalid: 1'b0};
        end else if (cls_b == CL_ZERO) begin
            res = '{special: 1'b1, value: a, invalid: 1'b0};
        end
    end

endmodule

// File: rtl/dpadd_core.sv
module dpadd_core
    import dpadd_pkg::*;
(
    input  wide_num_t a,
    input  wide_num_t b,
    output wide_num_t res,
    output logic      exact_zero
);

    logic            a_big;
    logic [XE_W-1:0] e_hi;
    logic [XE_W-1:0] sh;
    logic [XM_W-1:0] ma;
    logic [XM_W-1:0] mb;
    logic [XM_W:0]   sum;
    logic [XM_W-1:0] dif;
    logic [LZ_W-1:0] lz;

    always_comb begin
        a_big = ($signed(a.exp) >= $signed(b.exp));
        if (a_big) begin
            e_hi = a.exp;
            sh   = a.exp - b.exp;
            ma   = a.mant;
            mb   = shr_sticky(b.mant, sh);
        end else begin
            e_hi = b.exp;
            sh   = b.exp - a.exp;
            ma   = shr_sticky(a.mant, sh);
            mb   = b.mant;
        end

        sum        = {1'b0, ma} + {1'b0, mb};
        dif        = '0;
        lz         = '0;
        exact_zero = 1'b0;
        res.sign   = a.sign;
        res.exp    = e_hi;
        res.mant   = sum[XM_W-1:0];

        if (a.sign == b.sign) begin
            if (sum[XM_W]) begin
                res.mant = {sum[XM_W:2], sum[1] | sum[0]};
                res.exp  = e_hi + XE_W'(1);
            end
        end else begin
            if (ma >= mb) begin
                dif      = ma - mb;
                res.sign = a.sign;
            end else begin
                dif      = mb - ma;
                res.sign = b.sign;
            end
            exact_zero = (dif == '0);
            lz         = lead_zeros(dif);
            res.mant   = dif << lz;
            res.exp    = e_hi - XE_W'(lz);
        end
    end

endmodule

// File: rtl/dp_add_front.sv
module dp_add_front
    import dpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [1:0]        rm,
    output logic              out_vld,
    output logic              out_special,
    output logic [63:0]       out_value,
    output logic              out_invalid,
    output logic              out_sign,
    output logic signed [12:0] out_exp,
    output logic [55:0]       out_mant
);

    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ops  [N_OPS];
    opclass_e          cls  [N_OPS];
    wide_num_t         nums [N_OPS];

    spec_res_t sres;
    wide_num_t ares;
    logic      azero;

    spec_res_t nxt_spec;
    wide_num_t nxt_num;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
        dpadd_unpack u_unp (
            .op  (ops[g]),
            .cls (cls[g]),
            .num (nums[g])
        );
    end

    dpadd_special u_spec (
        .a     (op_a),
        .b     (op_b),
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .rm    (rm),
        .res   (sres)
    );

    dpadd_core u_core (
        .a          (nums[0]),
        .b          (nums[1]),
        .res        (ares),
        .exact_zero (azero)
    );

    always_comb begin
        nxt_spec = '0;
        nxt_num  = '0;
        if (sres.special) begin
            nxt_spec = sres;
        end else if (azero) begin
            nxt_spec = '{special: 1'b1,
                         value: {rm == RM_DOWN, {(WORD_W-1){1'b0}}},
                         invalid: 1'b0};
        end else begin
            nxt_num = ares;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld     <= 1'b0;
            out_special <= 1'b0;
            out_value   <= '0;
            out_invalid <= 1'b0;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_mant    <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_special <= nxt_spec.special;
                out_value   <= nxt_spec.value;
                out_invalid <= nxt_spec.invalid;
                out_sign    <= nxt_num.sign;
                out_exp     <= nxt_num.exp;
                out_mant    <= nxt_num.mant;
            end
        end
    end

endmodule

// File: rtl/dp_add_front_chk.sv
module dp_add_front_chk (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              out_vld,
    input logic              out_special,
    input logic [63:0]       out_value,
    input logic              out_invalid,
    input logic              out_sign,
    input logic signed [12:0] out_exp,
    input logic [55:0]       out_mant
);

    // R2: a sampled strobe yields a result one edge later
    p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(in_vld) && !$past(rst)) |-> out_vld);

    // R2: no strobe, no result, and the data registers hold
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_vld) && !$past(rst)) |->
            (!out_vld && $stable(out_value) && $stable(out_mant) &&
             $stable(out_exp) && $stable(out_special)));

    // R3: invalid is only raised together with a finished quiet NaN
    p_invalid_is_qnan_r3: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_special && (out_value[62:52] == 11'h7FF) && out_value[51]));

    // R13: arithmetic results leave with the hidden bit set
    p_normalized_r13: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_special) |-> out_mant[55]);

    // R11: exponent never exceeds one above the largest finite biased value
    p_exp_ceiling_r11: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_special) |-> (out_exp <= 13'sd2047));

    // R14: the two result forms never share nonzero fields
    p_field_split_r14: assert property (@(posedge clk) disable iff (rst)
        out_special |-> (!out_sign && out_exp == '0 && out_mant == '0));

    p_value_split_r14: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_special) |-> (out_value == '0 && !out_invalid));

endmodule

bind dp_add_front dp_add_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .out_vld     (out_vld),
    .out_special (out_special),
    .out_value   (out_value),
    .out_invalid (out_invalid),
    .out_sign    (out_sign),
    .out_exp     (out_exp),
    .out_mant    (out_mant)
);

// File: tb/sim_dp_add_front.sv
`timescale 1ns/1ps
module sim_dp_add_front;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic [63:0]       op_a = '0;
    logic [63:0]       op_b = '0;
    logic [1:0]        rm = 2'b00;
    logic              out_vld;
    logic              out_special;
    logic [63:0]       out_value;
    logic              out_invalid;
    logic              out_sign;
    logic signed [12:0] out_exp;
    logic [55:0]       out_mant;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dp_add_front u0 (
        .clk (clk), .rst (rst), .in_vld (in_vld),
        .op_a (op_a), .op_b (op_b), .rm (rm),
        .out_vld (out_vld), .out_special (out_special), .out_value (out_value),
        .out_invalid (out_invalid), .out_sign (out_sign),
        .out_exp (out_exp), .out_mant (out_mant)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  rm;
        logic        spec;
        logic [63:0] val;
        logic        inv;
        logic        sgn;
        logic [12:0] ex;
        logic [55:0] mant;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{"R3 ", 64'h7FF0000000000001, 64'h3FF0000000000000, 2'd0, 1'b1, 64'h7FF8000000000001, 1'b1, 1'b0, 13'h0, 56'h0},
        '{"R3 ", 64'h7FF0000000000001, 64'hFFF0000000000002, 2'd0, 1'b1, 64'h7FF8000000000001, 1'b1, 1'b0, 13'h0, 56'h0},
        '{"R3 ", 64'h7FF8000000000005, 64'hFFF0000000000002, 2'd0, 1'b1, 64'hFFF8000000000002, 1'b1, 1'b0, 13'h0, 56'h0},
        '{"R4 ", 64'h7FF8000000000005, 64'hFFF8000000000007, 2'd0, 1'b1, 64'h7FF8000000000005, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R4 ", 64'h3FF0000000000000, 64'hFFF8000000000007, 2'd0, 1'b1, 64'hFFF8000000000007, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R5 ", 64'h7FF0000000000000, 64'h7FF0000000000000, 2'd0, 1'b1, 64'h7FF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R5 ", 64'hFFF0000000000000, 64'hFFF0000000000000, 2'd0, 1'b1, 64'hFFF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R5 ", 64'h7FF0000000000000, 64'hFFF0000000000000, 2'd0, 1'b1, 64'h7FF8000000000000, 1'b1, 1'b0, 13'h0, 56'h0},
        '{"R6 ", 64'hFFF0000000000000, 64'h3FF0000000000000, 2'd0, 1'b1, 64'hFFF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R6 ", 64'h0000000000000000, 64'h7FF0000000000000, 2'd0, 1'b1, 64'h7FF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R6 ", 64'h7FF0000000000000, 64'h0000000000000001, 2'd0, 1'b1, 64'h7FF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R7 ", 64'h0000000000000000, 64'h0000000000000000, 2'd0, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R7 ", 64'h8000000000000000, 64'h8000000000000000, 2'd0, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R7 ", 64'h0000000000000000, 64'h8000000000000000, 2'd0, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R7 ", 64'h0000000000000000, 64'h8000000000000000, 2'd3, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R7 ", 64'h8000000000000000, 64'h0000000000000000, 2'd2, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R8 ", 64'h0000000000000000, 64'h3FF0000000000000, 2'd0, 1'b1, 64'h3FF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R8 ", 64'h3FF0000000000000, 64'h8000000000000000, 2'd0, 1'b1, 64'h3FF0000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R8 ", 64'h0000000000000000, 64'h8000000000000001, 2'd3, 1'b1, 64'h8000000000000001, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R11", 64'h3FF0000000000000, 64'h3FF0000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h400, 56'h80000000000000},
        '{"R10", 64'h3FF0000000000000, 64'h4000000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h400, 56'hC0000000000000},
        '{"R10", 64'h3FF0000000000000, 64'h3CA0000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h3FF, 56'h80000000000004},
        '{"R10", 64'h3C90000000000000, 64'h3FF0000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h3FF, 56'h80000000000002},
        '{"R10", 64'h3FF0000000000000, 64'h3C30000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h3FF, 56'h80000000000001},
        '{"R12", 64'h4000000000000000, 64'hBFF0000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h3FF, 56'h80000000000000},
        '{"R12", 64'h3FF0000000000000, 64'hC000000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b1, 13'h3FF, 56'h80000000000000},
        '{"R12", 64'h3FF0000000000000, 64'hBFF0000000000000, 2'd0, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R12", 64'h3FF0000000000000, 64'hBFF0000000000000, 2'd3, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 13'h0, 56'h0},
        '{"R13", 64'h3FF0000000000000, 64'hBC30000000000000, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h3FE, 56'hFFFFFFFFFFFFFE},
        '{"R9 ", 64'h0000000000000001, 64'h0000000000000001, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h1FCE, 56'h80000000000000},
        '{"R9 ", 64'h0000000000000003, 64'h8000000000000001, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h1FCE, 56'h80000000000000},
        '{"R9 ", 64'h0010000000000000, 64'h0000000000000001, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h001, 56'h80000000000008},
        '{"R11", 64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h7FF, 56'hFFFFFFFFFFFFF8},
        '{"R11", 64'h3FFFFFFFFFFFFFFF, 64'h3CB0000000000001, 2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 13'h400, 56'h80000000000001},
        '{"R13", 64'h3FF0000000000000, 64'hBFF0000000000001, 2'd0, 1'b0, 64'h0, 1'b0, 1'b1, 13'h3CB, 56'h80000000000000}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input vec_t v, input int idx);
        string req;
        req = $sformatf("%s vec%0d", v.tag, idx);
        chk(req, "out_vld",     64'(out_vld),     64'd1);
        chk(req, "out_special", 64'(out_special), 64'(v.spec));
        chk(req, "out_value",   out_value,        v.val);
        chk(req, "out_invalid", 64'(out_invalid), 64'(v.inv));
        chk(req, "out_sign",    64'(out_sign),    64'(v.sgn));
        chk(req, "out_exp",     64'(out_exp[12:0]), 64'(v.ex));
        chk(req, "out_mant",    64'(out_mant),    64'(v.mant));
    endtask

    task automatic drive(input vec_t v);
        op_a   = v.a;
        op_b   = v.b;
        rm     = v.rm;
        in_vld = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk("R1", "out_vld",     64'(out_vld),     64'd0);
        chk("R1", "out_special", 64'(out_special), 64'd0);
        chk("R1", "out_value",   out_value,        64'd0);
        chk("R1", "out_mant",    64'(out_mant),    64'd0);
        chk("R1", "out_exp",     64'(out_exp[12:0]), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            in_vld = 1'b0;
            chk_vec(VEC[i], i);
            @(negedge clk);
        end

        // R2: idle cycle holds data and drops out_vld, even with new operands present
        drive(VEC[19]);
        @(negedge clk);
        in_vld = 1'b0;
        op_a   = 64'h7FF0000000000001;
        op_b   = 64'h0;
        @(negedge clk);
        chk("R2", "idle out_vld",  64'(out_vld),  64'd0);
        chk("R2", "idle out_mant", 64'(out_mant), 64'h80000000000000);
        chk("R2", "idle out_exp",  64'(out_exp[12:0]), 64'h400);
        chk("R2", "idle out_invalid", 64'(out_invalid), 64'd0);

        // R2: back-to-back operands give results on consecutive cycles
        drive(VEC[7]);
        @(negedge clk);
        drive(VEC[33]);
        chk_vec(VEC[7], 7);
        @(negedge clk);
        in_vld = 1'b0;
        chk_vec(VEC[33], 33);
        @(negedge clk);

        // R1: reset in mid-run clears the loaded result
        drive(VEC[2]);
        @(negedge clk);
        in_vld = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        chk("R1", "mid out_vld",     64'(out_vld),     64'd0);
        chk("R1", "mid out_value",   out_value,        64'd0);
        chk("R1", "mid out_invalid", 64'(out_invalid), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule